// File: doc/BRIEF.md
# Event Counter Bank with Overflow Freeze

This block holds a small set of generic event counters for performance monitoring. Each counter has a control word and a data word. The control word enables the counter, picks one of four event sources, and decides whether an overflow should interrupt. Two sources are the retired-instruction pulse and the clock itself. Both are counted only while the power-state input reports a running state. The other two are external event pulses, which are counted in every power state.

When a counter wraps from all-ones to zero, the block latches a sticky overflow flag for that slot. If the counter's interrupt enable is set, the block also latches a sticky global freeze flag. The freeze flag stops every counter and asserts a level interrupt. Software reads the flags through one status word and clears them by writing that word.

The status space has eight overflow slots, but only the first four are backed by counters. The upper slots always read as zero. The status words for counter slots that do not exist also read as zero.

Top module: `pmu_ovf_unit`

## Requirements
- R1: A counter whose control word has enable (bit 4) set adds exactly 1 per clock in which its selected event is high, the freeze flag is 0, and its power gate is open. A write to a data word (addresses 8..11) loads the written value, and the counter does not also count in that cycle.
- R2: Source select (control bits 1:0) chooses the event: 0 is the retired-instruction pulse and 1 is every clock. Sources 0 and 1 count only when the power state is 0 (normal) or 1 (low power). Select values 2 and 3 choose external events 0 and 1, which count in any of the four power states.
- R3: When a counter counts from all-ones, it holds zero after that edge, and its overflow flag (status bit 8+n at address 0) is 1 at the same edge.
- R4: When a wrapping counter has interrupt enable (control bit 5) set, the freeze flag (status bit 0) and the interrupt output are 1 at the same edge as the overflow flag.
- R5: A wrapping counter with interrupt enable clear sets only its overflow flag. The freeze flag and the interrupt are left unchanged.
- R6: While the freeze flag is 1, no counter changes except through a data-word write. Counting resumes once software writes the freeze flag to 0.
- R7: The overflow flags and the freeze flag are sticky. Only a write to address 0 changes them, and that write loads status bit 0 and bits 15:8. If hardware sets a flag in the same cycle as the write, the hardware set wins.
- R8: Counters that wrap in the same cycle all get their overflow flags set at that edge.
- R9: Overflow slots 4..7 (status bits 15:12) always read 0, and writes to them have no effect. Addresses 1..3 and 12..15 read 0.
- R10: The interrupt output is 1 exactly when the freeze flag is 1 and at least one counter has both its overflow flag and its interrupt enable at 1.
- R11: After reset, every counter, control word and flag is zero. A control word reads back bits 5, 4, 1 and 0 as written, and all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One pulse per instruction retired without a fault, no-ops and predicated-off instructions included |
| ext_evt_i | input | 2 | External event pulses, selected by source values 2 and 3 |
| pwr_state_i | input | 2 | Power state: 0 normal, 1 low power, 2 and 3 halted states |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address: 0 status, 4..7 control, 8..11 data |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address, same map as the write address |
| rd_data_o | output | 32 | Combinational read data |
| pmi_o | output | 1 | Level performance-monitor interrupt |

## Verification
The embedded properties check four things on every cycle. They check that a frozen counter holds its value. They check that a wrap leaves zero and always lands in the overflow flags, with the freeze flag set when interrupt enable is on. They also check that both kinds of flag stay set without a software write and that the unimplemented slots stay clear. Power-state gating per source, the exact increment count, the interrupt level under each mix of flags and enables, and the read-back map can only be shown by the bench. The bench runs directed sequences and a long random run that compares against a cycle model.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [1:0] {
        SRC_RETIRE = 2'd0,
        SRC_CLOCK  = 2'd1,
        SRC_EXT0   = 2'd2,
        SRC_EXT1   = 2'd3
    } evt_src_e;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_LOW   = 2'd1,
        PWR_HALT  = 2'd2,
        PWR_SLEEP = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic     irq_en;
        logic     enable;
        evt_src_e src;
    } ctr_ctl_t;

    // register map positions that software decodes
    localparam int CTL_SRC_LSB  = 0;
    localparam int CTL_EN_BIT   = 4;
    localparam int CTL_IRQ_BIT  = 5;
    localparam int STS_FRZ_BIT  = 0;
    localparam int STS_OVF_LSB  = 8;
    localparam int CTL_BASE     = 4;
    localparam int CNT_BASE     = 8;

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen_i,
    input  logic             pwr_open_i,
    input  logic [3:0]       evt_i,
    input  logic             ctl_wr_i,
    input  ctr_ctl_t         ctl_wdata_i,
    input  logic             cnt_wr_i,
    input  logic [CTR_W-1:0] cnt_wdata_i,
    output ctr_ctl_t         ctl_o,
    output logic [CTR_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        ctr_ctl_t         ctl;
        logic [CTR_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       gate_open;
    logic       step;
    logic       wrap_d;

    always_comb begin
        st_d      = st_q;
        gate_open = (st_q.ctl.src == SRC_RETIRE || st_q.ctl.src == SRC_CLOCK)
                    ? pwr_open_i : 1'b1;
        step      = st_q.ctl.enable && !frozen_i && evt_i[st_q.ctl.src] && gate_open;
        wrap_d    = 1'b0;
        if (ctl_wr_i) begin
            st_d.ctl = ctl_wdata_i;
        end
        if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_d   = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o  = st_q.ctl;
    assign cnt_o  = st_q.cnt;
    assign wrap_o = wrap_d;

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && !cnt_wr_i) |=> (st_q.cnt == $past(st_q.cnt))); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.cnt == '0)); // R3

endmodule

// File: rtl/pmu_status.sv
module pmu_status #(
    parameter int NUM_CTR = 4,
    parameter int SLOTS   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] wrap_i,
    input  logic [NUM_CTR-1:0] irq_en_i,
    input  logic               sw_wr_i,
    input  logic               sw_frz_i,
    input  logic [SLOTS-1:0]   sw_ovf_i,
    output logic [SLOTS-1:0]   ovf_o,
    output logic               frozen_o,
    output logic               irq_o
);

    localparam logic [SLOTS-1:0] IMPL_MASK = {SLOTS{1'b1}} >> (SLOTS - NUM_CTR);

    typedef struct packed {
        logic [SLOTS-1:0] ovf;
        logic             frz;
    } sts_state_t;

    sts_state_t       st_d, st_q;
    logic [SLOTS-1:0] wrap_ext;
    logic [SLOTS-1:0] irq_en_ext;

    assign wrap_ext   = SLOTS'(wrap_i);
    assign irq_en_ext = SLOTS'(irq_en_i);

    always_comb begin
        st_d = st_q;
        if (sw_wr_i) begin
            st_d.ovf = sw_ovf_i & IMPL_MASK;
            st_d.frz = sw_frz_i;
        end
        st_d.ovf = st_d.ovf | wrap_ext;
        st_d.frz = st_d.frz | (|(wrap_i & irq_en_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_o    = st_q.ovf;
    assign frozen_o = st_q.frz;
    assign irq_o    = st_q.frz && (|(st_q.ovf & irq_en_ext));

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_i |=> ((st_q.ovf & $past(st_q.ovf)) == $past(st_q.ovf))); // R7

    AST_FRZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.frz && !sw_wr_i) |=> st_q.frz); // R7

    AST_WRAP_SETS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_i) |=> ((st_q.ovf & $past(wrap_ext)) == $past(wrap_ext))); // R8

    AST_IRQ_WRAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wrap_i & irq_en_i)) |=> (st_q.frz && irq_o)); // R4

    AST_UNIMPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ovf & ~IMPL_MASK) == '0)); // R9

endmodule

// File: rtl/pmu_ovf_unit.sv
module pmu_ovf_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32,
    parameter int SLOTS   = 8,
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    input  logic [1:0]        ext_evt_i,
    input  logic [1:0]        pwr_state_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              pmi_o
);

    ctr_ctl_t           ctl_w  [NUM_CTR];
    logic [CTR_W-1:0]   cnt_w  [NUM_CTR];
    logic [NUM_CTR-1:0] wrap_w;
    logic [NUM_CTR-1:0] irq_en_w;
    logic [SLOTS-1:0]   ovf_w;
    logic               frozen_w;
    logic               pwr_open;
    logic [3:0]         evt_vec;
    ctr_ctl_t           ctl_wdata;
    logic               sts_wr;

    assign pwr_open  = (pwr_state_e'(pwr_state_i) == PWR_RUN) ||
                       (pwr_state_e'(pwr_state_i) == PWR_LOW);
    assign evt_vec   = {ext_evt_i[1], ext_evt_i[0], 1'b1, retire_i};
    assign ctl_wdata = '{irq_en: wr_data_i[CTL_IRQ_BIT],
                         enable: wr_data_i[CTL_EN_BIT],
                         src:    evt_src_e'(wr_data_i[CTL_SRC_LSB +: 2])};
    assign sts_wr    = wr_en_i && (wr_addr_i == '0);

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        pmu_counter #(.CTR_W(CTR_W)) ctr_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .frozen_i    (frozen_w),
            .pwr_open_i  (pwr_open),
            .evt_i       (evt_vec),
            .ctl_wr_i    (wr_en_i && (wr_addr_i == ADDR_W'(CTL_BASE + n))),
            .ctl_wdata_i (ctl_wdata),
            .cnt_wr_i    (wr_en_i && (wr_addr_i == ADDR_W'(CNT_BASE + n))),
            .cnt_wdata_i (wr_data_i[CTR_W-1:0]),
            .ctl_o       (ctl_w[n]),
            .cnt_o       (cnt_w[n]),
            .wrap_o      (wrap_w[n])
        );
        assign irq_en_w[n] = ctl_w[n].irq_en;
    end

    pmu_status #(.NUM_CTR(NUM_CTR), .SLOTS(SLOTS)) sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap_w),
        .irq_en_i (irq_en_w),
        .sw_wr_i  (sts_wr),
        .sw_frz_i (wr_data_i[STS_FRZ_BIT]),
        .sw_ovf_i (wr_data_i[STS_OVF_LSB +: SLOTS]),
        .ovf_o    (ovf_w),
        .frozen_o (frozen_w),
        .irq_o    (pmi_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == '0) begin
            rd_data_o[STS_FRZ_BIT]           = frozen_w;
            rd_data_o[STS_OVF_LSB +: SLOTS]  = ovf_w;
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            if (rd_addr_i == ADDR_W'(CTL_BASE + n)) begin
                rd_data_o[CTL_SRC_LSB +: 2] = ctl_w[n].src;
                rd_data_o[CTL_EN_BIT]       = ctl_w[n].enable;
                rd_data_o[CTL_IRQ_BIT]      = ctl_w[n].irq_en;
            end
            if (rd_addr_i == ADDR_W'(CNT_BASE + n)) begin
                rd_data_o = REG_W'(cnt_w[n]);
            end
        end
    end

    AST_RESUME_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_w && !sts_wr) |=> frozen_w); // R6

endmodule

// File: tb/pmu_ovf_unit_tb_top.sv
`timescale 1ns/100ps
module pmu_ovf_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic [1:0]  ext = '0;
    logic [1:0]  pwr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_cnt [4];
    logic [31:0] m_ctl [4];
    logic [7:0]  m_ovf;
    logic        m_fr;

    always #2.5 clk = ~clk;

    pmu_ovf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .ext_evt_i(ext),
        .pwr_state_i(pwr), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pmi_o(irq)
    );

    function automatic logic [31:0] exp_read(logic [3:0] a);
        if (a == 4'd0) return {16'h0, m_ovf, 7'h0, m_fr};
        if (a >= 4'd4 && a <= 4'd7) return m_ctl[a - 4];
        if (a >= 4'd8 && a <= 4'd11) return m_cnt[a - 8];
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int n = 0; n < 4; n++) any |= m_ovf[n] & m_ctl[n][5];
        return m_fr & any;
    endfunction

    function automatic string tag_of(logic [3:0] a);
        if (a == 4'd0) return "R7";
        if (a >= 4'd4 && a <= 4'd7) return "R11";
        if (a >= 4'd8 && a <= 4'd11) return "R1";
        return "R9";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_model(logic [3:0] a);
        rd_addr = a;
        #0.1;
        chk(tag_of(a), rd_data, exp_read(a));
    endtask

    task automatic rd_const(logic [3:0] a, string tag, logic [31:0] v);
        rd_addr = a;
        #0.1;
        chk(tag, rd_data, v);
        chk(tag, rd_data, exp_read(a));
    endtask

    // one clock: inputs already applied; model advances alongside the design
    task automatic tick();
        logic [31:0] n_cnt [4];
        logic [31:0] n_ctl [4];
        logic [7:0]  n_ovf;
        logic        n_fr;
        logic [3:0]  wrap;
        for (int n = 0; n < 4; n++) begin
            logic [1:0] sel;
            logic ev, gate, inc;
            sel  = m_ctl[n][1:0];
            ev   = (sel == 2'd0) ? retire : (sel == 2'd1) ? 1'b1 : ext[sel - 2'd2];
            gate = (sel >= 2'd2) || (pwr <= 2'd1);
            inc  = m_ctl[n][4] && !m_fr && ev && gate;
            wrap[n]  = 1'b0;
            n_cnt[n] = m_cnt[n];
            n_ctl[n] = m_ctl[n];
            if (wr_en && wr_addr == 4'(8 + n)) n_cnt[n] = wr_data;
            else if (inc) begin
                wrap[n]  = (m_cnt[n] == 32'hFFFF_FFFF);
                n_cnt[n] = m_cnt[n] + 1;
            end
            if (wr_en && wr_addr == 4'(4 + n)) n_ctl[n] = wr_data & 32'h33;
        end
        n_ovf = m_ovf;
        n_fr  = m_fr;
        if (wr_en && wr_addr == 4'd0) begin
            n_ovf = wr_data[15:8] & 8'h0F;
            n_fr  = wr_data[0];
        end
        n_ovf |= {4'h0, wrap};
        for (int n = 0; n < 4; n++) if (wrap[n] && m_ctl[n][5]) n_fr = 1'b1;
        @(posedge clk);
        #0.5;
        for (int n = 0; n < 4; n++) begin
            m_cnt[n] = n_cnt[n];
            m_ctl[n] = n_ctl[n];
        end
        m_ovf = n_ovf;
        m_fr  = n_fr;
    endtask

    task automatic drive(logic r, logic [1:0] e, logic [1:0] p,
                         logic we, logic [3:0] wa, logic [31:0] wd);
        retire = r; ext = e; pwr = p; wr_en = we; wr_addr = wa; wr_data = wd;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(int k, logic r, logic [1:0] e, logic [1:0] p);
        for (int i = 0; i < k; i++) drive(r, e, p, 1'b0, 4'd0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int n = 0; n < 4; n++) begin m_cnt[n] = '0; m_ctl[n] = '0; end
        m_ovf = '0;
        m_fr  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        for (int a = 0; a < 16; a++) rd_const(4'(a), "R11", 32'h0);
        chk("R11", 32'(irq), 32'h0);

        // R2: clock source blocked in halt, R1: counts in run
        drive(0, 2'b00, 2'd2, 1, 4'd4, 32'hFFFF_FFD1);
        rd_const(4'd4, "R11", 32'h11);
        idle(3, 0, 2'b00, 2'd2);
        rd_const(4'd8, "R2", 32'd0);
        idle(3, 0, 2'b00, 2'd0);
        rd_const(4'd8, "R1", 32'd3);
        idle(2, 0, 2'b00, 2'd1);
        rd_const(4'd8, "R2", 32'd5);
        drive(0, 2'b00, 2'd3, 1, 4'd4, 32'h0);

        // R5/R3: wrap without interrupt enable
        drive(0, 2'b00, 2'd0, 1, 4'd5, 32'h10);
        drive(0, 2'b00, 2'd0, 1, 4'd9, 32'hFFFF_FFFF);
        drive(1, 2'b00, 2'd0, 0, 4'd0, 32'h0);
        rd_const(4'd9, "R3", 32'h0);
        rd_const(4'd0, "R5", 32'h0000_0200);
        chk("R5", 32'(irq), 32'h0);

        // R8/R4: two interrupt-enabled counters wrap together in sleep state
        drive(0, 2'b00, 2'd3, 1, 4'd6, 32'h32);
        drive(0, 2'b00, 2'd3, 1, 4'd7, 32'h33);
        drive(0, 2'b00, 2'd3, 1, 4'd10, 32'hFFFF_FFFF);
        drive(0, 2'b00, 2'd3, 1, 4'd11, 32'hFFFF_FFFF);
        drive(0, 2'b11, 2'd3, 0, 4'd0, 32'h0);
        rd_const(4'd0, "R8", 32'h0000_0E01);
        chk("R4", 32'(irq), 32'h1);

        // R6: frozen, nothing counts
        idle(4, 1, 2'b11, 2'd0);
        rd_const(4'd9, "R6", 32'h0);
        rd_const(4'd10, "R6", 32'h0);
        rd_const(4'd11, "R6", 32'h0);

        // R9: unimplemented slots ignore writes
        drive(0, 2'b00, 2'd0, 1, 4'd0, 32'h0000_F601);
        rd_const(4'd0, "R9", 32'h0000_0601);
        chk("R10", 32'(irq), 32'h1);
        idle(3, 0, 2'b00, 2'd0);
        rd_const(4'd0, "R7", 32'h0000_0601);

        // R10: freeze cleared drops interrupt; R6: counting resumes
        drive(0, 2'b00, 2'd0, 1, 4'd0, 32'h0000_0600);
        chk("R10", 32'(irq), 32'h0);
        drive(0, 2'b01, 2'd0, 0, 4'd0, 32'h0);
        rd_const(4'd10, "R6", 32'h1);
        drive(0, 2'b00, 2'd0, 1, 4'd0, 32'h0000_0001);
        chk("R10", 32'(irq), 32'h0);
        drive(0, 2'b00, 2'd0, 1, 4'd0, 32'h0000_0401);
        chk("R10", 32'(irq), 32'h1);
        drive(0, 2'b00, 2'd0, 1, 4'd0, 32'h0);

        // random run against the cycle model
        void'($urandom(32'd7));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  wa;
            logic [31:0] wd;
            logic        we;
            we = ($urandom_range(0, 5) == 0);
            wa = 4'($urandom_range(0, 15));
            wd = $urandom;
            if (wa >= 4'd8 && wa <= 4'd11 && $urandom_range(0, 1) == 1)
                wd = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
            if (wa == 4'd0 && $urandom_range(0, 2) != 0) wd[0] = 1'b0;
            drive(1'($urandom), 2'($urandom), 2'($urandom), we, wa, wd);
            chk("R10", 32'(irq), 32'(exp_irq()));
            rd_model(4'($urandom_range(0, 15)));
        end
        finish_run();
    end

endmodule